// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block steps the control word of a SuperSpeed USB PHY through its power-up and power-down sequences, so software only issues one command and waits for completion. An init command pulses the PHY reset bit on top of the current control value. The block then restores that value and selects the reference source from a strap that reports whether an external crystal is fitted. It waits for the reference clock to settle, and finally turns on PHY enable and lane-0 power present together.

An exit command takes the PHY down in three single-cycle steps, in a fixed order. First PHY enable is cleared, then the pad-reference select is cleared, and last the test power-down bit is written to its retention level. The reset pulse length and the settle wait are parameters counted in reference clock cycles. Defaults are 2 ms and 30 ms at 125 MHz, and a test build shortens them. A busy flag covers each sequence, and a one-cycle done pulse marks its end.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: A synchronous active-high `rst` sets the whole control word to 0 and clears busy and done, including in the middle of a sequence.
- R2: Only these bits of `phy_ctrl` are ever driven: 7 = PHY reset, 8 = PHY enable, 24 = lane-0 power present, 27 = test power-down, 28 = reference-from-pad select. All other bits are 0.
- R3: On an accepted init, bit 7 is set on top of the current word at the accepting edge. It stays set for exactly `RST_CYC` cycles, and then the word before the command is restored in full.
- R4: One cycle after the restore, a single update sets bit 28 equal to `xtal_present` and clears bit 27. The other bits are left unchanged.
- R5: Bits 8 and 24 are set in the same update, `RST_CYC + SETTLE_CYC + 1` clock edges after the accepting edge.
- R6: An accepted exit clears bit 8 at the accepting edge, clears bit 28 at the next edge, and sets bit 27 to `RETAIN_PD` (default 1) at the edge after that. Bit 24 is not changed.
- R7: `busy` is high from the cycle after the accepting edge until the final update of the sequence. `done` is high for exactly the one cycle following that final update, and `busy` is low in that cycle.
- R8: Init and exit requests that arrive while `busy` is high are ignored. The sequence in progress keeps its timing, and no second sequence follows it.
- R9: If init and exit are both requested while idle, init is taken and exit is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all delays are counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| init_req | input | 1 | Starts the power-up sequence when idle |
| exit_req | input | 1 | Starts the power-down sequence when idle |
| xtal_present | input | 1 | Strap: an external crystal reference is fitted |
| phy_ctrl | output | 32 | PHY control word (bit map in R2) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence finishes |

## Verification
The assertions assume that `RST_CYC` and `SETTLE_CYC` are at least 1. They also assume that `xtal_present` is a static strap, so a change of the pad bit during init comes only from the reference-select step. The stimulus follows both assumptions: it builds the block with small positive delays, and it changes the strap only while the block is idle. It drives requests as one-cycle pulses, half a cycle away from the active edge. Requests made while busy, and a reset in the middle of a sequence, are placed at chosen cycles inside the reset hold and the exit steps.

// File: rtl/upsq_pkg.sv
package upsq_pkg;
  localparam int CW       = 32;
  localparam int BIT_RST  = 7;
  localparam int BIT_EN   = 8;
  localparam int BIT_LANE = 24;
  localparam int BIT_PD   = 27;
  localparam int BIT_PAD  = 28;

  typedef enum logic [2:0] {
    S_IDLE, S_RSTHOLD, S_REFSEL, S_SETTLE, S_XPAD, S_XPD
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_RST_ON, OP_RESTORE, OP_REFSEL,
    OP_ENABLE, OP_CLR_EN, OP_CLR_PAD, OP_RETAIN
  } ctl_op_t;

  typedef struct packed {
    logic pad;
    logic pd;
    logic lane;
    logic en;
    logic rst;
  } ctl_bits_t;
endpackage

// File: rtl/upsq_timer.sv
module upsq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/upsq_fsm.sv
module upsq_fsm
  import upsq_pkg::*;
#(
  parameter int RST_CYC    = 250000,
  parameter int SETTLE_CYC = 3750000,
  parameter int W          = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_req,
  input  logic         exit_req,
  input  logic         tmr_zero,
  output ctl_op_t      op,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         busy,
  output logic         done
);
  localparam logic [W-1:0] RST_LD = W'(RST_CYC - 1);
  localparam logic [W-1:0] SET_LD = W'(SETTLE_CYC - 1);

  seq_state_t st, nxt;
  logic       fin;

  always_comb begin
    nxt      = st;
    op       = OP_NONE;
    tmr_load = 1'b0;
    tmr_val  = '0;
    fin      = 1'b0;
    case (st)
      S_IDLE: begin
        if (init_req) begin
          op       = OP_RST_ON;
          tmr_load = 1'b1;
          tmr_val  = RST_LD;
          nxt      = S_RSTHOLD;
        end else if (exit_req) begin
          op  = OP_CLR_EN;
          nxt = S_XPAD;
        end
      end
      S_RSTHOLD: begin
        if (tmr_zero) begin
          op  = OP_RESTORE;
          nxt = S_REFSEL;
        end
      end
      S_REFSEL: begin
        op       = OP_REFSEL;
        tmr_load = 1'b1;
        tmr_val  = SET_LD;
        nxt      = S_SETTLE;
      end
      S_SETTLE: begin
        if (tmr_zero) begin
          op  = OP_ENABLE;
          fin = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_XPAD: begin
        op  = OP_CLR_PAD;
        nxt = S_XPD;
      end
      S_XPD: begin
        op  = OP_RETAIN;
        fin = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      busy <= (nxt != S_IDLE);
      done <= fin;
    end
  end
endmodule

// File: rtl/upsq_ctrl_reg.sv
module upsq_ctrl_reg
  import upsq_pkg::*;
#(
  parameter bit RETAIN_PD = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_op_t       op,
  input  logic          xtal_present,
  output logic [CW-1:0] word
);
  ctl_bits_t cur, sav;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      sav <= '0;
    end else begin
      case (op)
        OP_RST_ON: begin
          sav     <= cur;
          cur.rst <= 1'b1;
        end
        OP_RESTORE: cur <= sav;
        OP_REFSEL: begin
          cur.pad <= xtal_present;
          cur.pd  <= 1'b0;
        end
        OP_ENABLE: begin
          cur.en   <= 1'b1;
          cur.lane <= 1'b1;
        end
        OP_CLR_EN:  cur.en  <= 1'b0;
        OP_CLR_PAD: cur.pad <= 1'b0;
        OP_RETAIN:  cur.pd  <= RETAIN_PD;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < CW; i++) begin : g_map
    if (i == BIT_RST)       begin : g_r assign word[i] = cur.rst;  end
    else if (i == BIT_EN)   begin : g_e assign word[i] = cur.en;   end
    else if (i == BIT_LANE) begin : g_l assign word[i] = cur.lane; end
    else if (i == BIT_PD)   begin : g_d assign word[i] = cur.pd;   end
    else if (i == BIT_PAD)  begin : g_p assign word[i] = cur.pad;  end
    else                    begin : g_z assign word[i] = 1'b0;     end
  end
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
  import upsq_pkg::*;
#(
  parameter int RST_CYC    = 250000,
  parameter int SETTLE_CYC = 3750000,
  parameter bit RETAIN_PD  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  input  logic          exit_req,
  input  logic          xtal_present,
  output logic [CW-1:0] phy_ctrl,
  output logic          busy,
  output logic          done
);
  localparam int MAXC = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int W    = $clog2(MAXC + 1);

  ctl_op_t      op;
  logic         tmr_load, tmr_zero;
  logic [W-1:0] tmr_val;

  upsq_fsm #(.RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .W(W)) u_fsm (
    .clk(clk), .rst(rst), .init_req(init_req), .exit_req(exit_req),
    .tmr_zero(tmr_zero), .op(op), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .busy(busy), .done(done)
  );

  upsq_timer #(.W(W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  upsq_ctrl_reg #(.RETAIN_PD(RETAIN_PD)) u_ctl (
    .clk(clk), .rst(rst), .op(op), .xtal_present(xtal_present), .word(phy_ctrl)
  );
endmodule

// File: rtl/upsq_chk.sv
module upsq_chk
  import upsq_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] phy_ctrl,
  input logic          busy,
  input logic          done
);
  localparam logic [CW-1:0] USED = (CW'(1) << BIT_RST) | (CW'(1) << BIT_EN) |
    (CW'(1) << BIT_LANE) | (CW'(1) << BIT_PD) | (CW'(1) << BIT_PAD);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phy_ctrl == '0 && !busy && !done));
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (phy_ctrl & ~USED) == '0);
  a_r3_rst_only_busy: assert property (@(posedge clk) disable iff (rst)
    phy_ctrl[BIT_RST] |-> busy);
  a_r5_enable_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_ctrl[BIT_EN]) |-> (done && phy_ctrl[BIT_LANE]));
  a_r6_retain_last: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_ctrl[BIT_PD]) |-> (!phy_ctrl[BIT_EN] && !phy_ctrl[BIT_PAD]));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind usbphy_pwr_seq upsq_chk u_chk (
  .clk(clk), .rst(rst), .phy_ctrl(phy_ctrl), .busy(busy), .done(done)
);

// File: tb/sim_usbphy_pwr_seq.sv
module sim_usbphy_pwr_seq;
  localparam int R = 12;
  localparam int S = 30;
  localparam logic [31:0] B_RST  = 32'h1 << 7;
  localparam logic [31:0] B_EN   = 32'h1 << 8;
  localparam logic [31:0] B_LANE = 32'h1 << 24;
  localparam logic [31:0] B_PD   = 32'h1 << 27;
  localparam logic [31:0] B_PAD  = 32'h1 << 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 1'b0, exit_req = 1'b0, xtal_present = 1'b1;
  logic [31:0] phy_ctrl;
  logic busy, done;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usbphy_pwr_seq #(.RST_CYC(R), .SETTLE_CYC(S), .RETAIN_PD(1'b1)) u0 (
    .clk(clk), .rst(rst), .init_req(init_req), .exit_req(exit_req),
    .xtal_present(xtal_present), .phy_ctrl(phy_ctrl), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // drive a one-cycle request; returns at the negedge after the accepting edge
  task automatic pulse(input logic i, input logic e);
    init_req = i; exit_req = e;
    step();
    init_req = 1'b0; exit_req = 1'b0;
  endtask

  task automatic t_reset();
    step();
    chk("R1 reset word", phy_ctrl, 32'h0);
    chk("R1 reset busy/done", {31'h0, busy | done}, 32'h0);
  endtask

  task automatic t_init(input logic x);
    logic [31:0] w0, wref;
    int bad = 0;
    w0 = phy_ctrl;
    xtal_present = x;
    pulse(1'b1, 1'b0);
    chk("R3 reset bit on top", phy_ctrl, w0 | B_RST);
    chk("R7 busy in init", {31'h0, busy}, 32'h1);
    for (int k = 1; k < R; k++) begin
      step();
      if (phy_ctrl !== (w0 | B_RST)) bad++;
    end
    chk("R3 reset held RST_CYC", bad, 0);
    step();
    chk("R3 restore", phy_ctrl, w0);
    step();
    wref = (w0 & ~(B_PAD | B_PD)) | (x ? B_PAD : 32'h0);
    chk("R4 ref select", phy_ctrl, wref);
    repeat (S - 1) step();
    chk("R5 not yet enabled", phy_ctrl, wref);
    step();
    chk("R5 enable+lane", phy_ctrl, wref | B_EN | B_LANE);
    chk("R7 done, not busy", {30'h0, done, busy}, 32'h2);
    step();
    chk("R7 done one cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic t_exit();
    logic [31:0] w0;
    w0 = phy_ctrl;
    pulse(1'b0, 1'b1);
    chk("R6 clear enable first", phy_ctrl, w0 & ~B_EN);
    chk("R7 busy in exit", {31'h0, busy}, 32'h1);
    step();
    chk("R6 clear pad second", phy_ctrl, w0 & ~(B_EN | B_PAD));
    step();
    chk("R6 retention last, lane kept", phy_ctrl, (w0 & ~(B_EN | B_PAD)) | B_PD);
    chk("R7 exit done", {30'h0, done, busy}, 32'h2);
    step();
    chk("R7 exit done one cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic t_ignore_busy();
    logic [31:0] w0;
    w0 = phy_ctrl;
    xtal_present = 1'b1;
    pulse(1'b1, 1'b0);
    step(); step();
    pulse(1'b0, 1'b1);
    repeat (R - 5) step();
    pulse(1'b1, 1'b0);
    step();
    chk("R8 restore unaffected", phy_ctrl, w0);
    repeat (S + 1) step();
    chk("R8 enable on time", phy_ctrl, ((w0 & ~B_PD) | B_PAD) | B_EN | B_LANE);
    chk("R8 done on time", {31'h0, done}, 32'h1);
    repeat (3) step();
    chk("R8 no extra sequence", {31'h0, busy}, 32'h0);
    w0 = phy_ctrl;
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    step();
    chk("R8 exit unaffected", phy_ctrl, (w0 & ~(B_EN | B_PAD)) | B_PD);
    step();
    chk("R8 idle after exit", {30'h0, busy, phy_ctrl[7]}, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] w0;
    w0 = phy_ctrl;
    pulse(1'b1, 1'b1);
    chk("R9 init wins", phy_ctrl, w0 | B_RST);
    repeat (R + S + 2) step();
    chk("R9 init completes", phy_ctrl & (B_EN | B_LANE), B_EN | B_LANE);
  endtask

  task automatic t_midreset();
    pulse(1'b1, 1'b0);
    repeat (4) step();
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 reset mid-sequence", phy_ctrl, 32'h0);
    chk("R1 reset mid-sequence busy", {31'h0, busy}, 32'h0);
    repeat (R + S + 4) step();
    chk("R1 stays idle", phy_ctrl, 32'h0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_init(1'b1);
    t_exit();
    t_init(1'b0);
    t_exit();
    t_ignore_busy();
    t_both();
    t_midreset();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule